// File: doc/BRIEF.md
# PCI configuration cycle engine

This block turns one host request into one PCI configuration access. The request carries a bus number, a device number, a function number, a byte offset into configuration space, an access size of 1, 2 or 4 bytes, a direction and write data. On bus 0 the engine forms a one-hot device-select address (Type 0). On any other bus it forms a routed address (Type 1). In both cases it maps the address into the sparse address space of a single-beat bus port.

For a Type 1 access the engine first switches a 2-bit configuration-mode field in an external bank-extension register. It runs the access, then puts the register back. After the bus acknowledges, the engine holds the request open for a fixed window of `WAIT_CYC` clocks and watches an error input. A read that sees an error returns all-ones. A write that sees an error still completes normally. Either kind of error sets a sticky status bit that the host clears.

The host side is a plain request/done handshake. Only one request is in flight at a time, and `busy` covers it from acceptance until `done`.

Top module: `cfg_cycle_engine`

## Requirements
- R1: On bus 0 the configuration address has only bit (11 + device) set within bits 31:11. The function is in bits 10:8, offset bits 7:2 are in bits 7:2, and bits 1:0 are 00.
- R2: On bus 0, a device number above `MAX_DEV0` (default 8) is rejected. No bus access is made. `done` comes 2 cycles after acceptance with `resp_nodev`=1 and `resp_rdata`=0xFFFFFFFF.
- R3: On a nonzero bus the configuration address is bus in 23:16, device in 15:11, function in 10:8 and offset bits 7:2 in bits 7:2. Bits 31:24 and 1:0 are zero.
- R4: Before a Type 1 access the engine saves `bext_q` with bits 31:30 cleared. It then writes the saved value with bits 31:30 = 01, so the field reads 01 while `bus_req` is high. After the access it writes back the saved value. A Type 0 access writes nothing to that register.
- R5: `bus_addr` is the configuration address shifted left by 5, plus (size − 1) × 8.
- R6: Read data is the bus word shifted right by 8 × offset[1:0]. Write data on the bus is the request data shifted left by 8 × offset[1:0].
- R7: `done` comes `WAIT_CYC`+1 cycles after the acknowledge cycle for bus 0, and `WAIT_CYC`+2 cycles after it for Type 1. An error is counted if it arrives with the acknowledge or up to `WAIT_CYC` cycles after it. An error that arrives later is ignored.
- R8: A read that saw a counted error returns 0xFFFFFFFF.
- R9: A write that saw a counted error still completes with `done` and `resp_nodev`=0.
- R10: A request is taken only when `busy` is low. `busy` stays high from acceptance up to and including the single-cycle `done` pulse. A request presented while busy is ignored and makes no bus access.
- R11: `abort_sticky` becomes 1 in the cycle after a `done` whose access saw an error. It stays 1 until `abort_clr` is raised, which clears it on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_fn | input | 3 | Function number |
| req_off | input | 8 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, right-aligned |
| abort_clr | input | 1 | Clears the sticky abort bit |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| resp_nodev | output | 1 | Device rejected, valid with done |
| resp_rdata | output | 32 | Read result, valid with done |
| abort_sticky | output | 1 | An access has seen an error since the last clear |
| bext_q | input | 32 | Current bank-extension register value |
| bext_we | output | 1 | Bank-extension register write strobe |
| bext_wd | output | 32 | Bank-extension register write value |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_write | output | 1 | Bus access direction |
| bus_addr | output | 37 | Sparse bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus access acknowledge |
| bus_rdata | input | 32 | Bus read data, valid with acknowledge |
| bus_err | input | 1 | Master-abort or error indication |

## Verification
Each result is due at a fixed number of clocks after a known event:
- A rejected request gives `done` 2 clocks after acceptance.
- An accepted access gives `done` `WAIT_CYC`+1 clocks after the acknowledge, or one clock more for Type 1. The bank-extension register is already restored by then.
- The sticky abort bit changes one clock after `done`.

The bench keeps a posedge counter and drives and samples only on falling edges. It stamps the acknowledge and acceptance cycles and compares the `done` cycle against those stamps. Error pulses are placed at offsets 0, `WAIT_CYC` and `WAIT_CYC`+1 from the acknowledge, which probe both edges of the window.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DATA_W    = 32;
  localparam int CFG_AW    = 32;
  localparam int SPARSE_SH = 5;
  localparam int BUS_AW    = CFG_AW + SPARSE_SH;
  localparam int MODE_HI   = 31;
  localparam int MODE_LO   = 30;
  localparam logic [1:0] MODE_ROUTED = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_MODE,
    ST_ACCESS,
    ST_WAIT,
    ST_RESTORE,
    ST_FINISH
  } cstate_t;

  typedef struct packed {
    logic              write;
    logic [7:0]        bus;
    logic [4:0]        dev;
    logic [2:0]        fn;
    logic [7:0]        off;
    logic [2:0]        size;
    logic [DATA_W-1:0] wdata;
  } creq_t;
endpackage

// File: rtl/cfgx_addr_gen.sv
module cfgx_addr_gen
  import cfgx_pkg::*;
#(
  parameter int MAX_DEV0 = 8
) (
  input  logic [7:0]        bus,
  input  logic [4:0]        dev,
  input  logic [2:0]        fn,
  input  logic [5:0]        dword,
  input  logic [2:0]        size,
  output logic              is_type1,
  output logic              is_nodev,
  output logic [BUS_AW-1:0] sparse_addr
);
  localparam logic [4:0] DEV_LIMIT = 5'(MAX_DEV0);

  logic [CFG_AW-1:0] cfg_addr;
  logic [2:0]        size_m1;

  assign is_type1 = (bus != 8'd0);
  assign is_nodev = !is_type1 && (dev > DEV_LIMIT);
  assign size_m1  = size - 3'd1;

  always_comb begin
    cfg_addr = '0;
    if (!is_type1) begin
      cfg_addr = 32'h0000_0800 << dev;
    end else begin
      cfg_addr[23:16] = bus;
      cfg_addr[15:11] = dev;
    end
    cfg_addr[10:8] = fn;
    cfg_addr[7:2]  = dword;
  end

  assign sparse_addr = {cfg_addr, {SPARSE_SH{1'b0}}}
                     + {{(BUS_AW-6){1'b0}}, size_m1, 3'b000};
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
  import cfgx_pkg::*;
(
  input  logic [1:0]        byte_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] raw_rdata,
  input  logic              force_ones,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic [4:0] shamt;

  assign shamt     = {byte_sel, 3'b000};
  assign bus_wdata = host_wdata << shamt;

  always_comb begin
    if (force_ones) host_rdata = '1;
    else            host_rdata = raw_rdata >> shamt;
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int WAIT_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_type1,
  input  logic              is_nodev,
  input  logic [DATA_W-1:0] bext_q,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              bus_req,
  output logic              bext_we,
  output logic [DATA_W-1:0] bext_wd,
  output logic [DATA_W-1:0] raw_rdata,
  output logic              err_seen,
  output logic              done
);
  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam logic [DATA_W-1:0] MODE_MASK =
    DATA_W'(3) << MODE_LO;
  localparam logic [DATA_W-1:0] MODE_SETV =
    DATA_W'(MODE_ROUTED) << MODE_LO;

  cstate_t           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] saved_q, saved_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              save_en, cap_en, cnt_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    saved_d  = bext_q & ~MODE_MASK;
    rdata_d  = bus_rdata;
    err_d    = err_q;
    save_en  = 1'b0;
    cap_en   = 1'b0;
    cnt_en   = 1'b0;
    bext_we  = 1'b0;
    bext_wd  = saved_q;
    bus_req  = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_CHECK;
          err_d = 1'b0;
        end
      end
      ST_CHECK: begin
        if (is_nodev) begin
          st_d = ST_FINISH;
        end else if (is_type1) begin
          save_en = 1'b1;
          st_d    = ST_MODE;
        end else begin
          st_d = ST_ACCESS;
        end
      end
      ST_MODE: begin
        bext_we = 1'b1;
        bext_wd = saved_q | MODE_SETV;
        st_d    = ST_ACCESS;
      end
      ST_ACCESS: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          cap_en = 1'b1;
          err_d  = bus_err;
          cnt_en = 1'b1;
          cnt_d  = '0;
          st_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        err_d = err_q | bus_err;
        if (cnt_q == CNT_LAST) begin
          st_d = is_type1 ? ST_RESTORE : ST_FINISH;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      ST_RESTORE: begin
        bext_we = 1'b1;
        bext_wd = saved_q;
        st_d    = ST_FINISH;
      end
      ST_FINISH: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      saved_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (cnt_en)  cnt_q   <= cnt_d;
      if (save_en) saved_q <= saved_d;
      if (cap_en)  rdata_q <= rdata_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign raw_rdata = rdata_q;
  assign err_seen  = err_q;

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy is held until done
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R4: routed mode is programmed in the cycle before the access starts
  a_r4_mode_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && is_type1) |->
      ($past(bext_we) && ($past(bext_wd[MODE_HI:MODE_LO]) == MODE_ROUTED)));

  // R4: a bus-0 access never touches the bank-extension register
  a_r4_type0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_type1) |-> !bext_we);

  // R2: a rejected device finishes without a bus access
  a_r2_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_nodev) |-> !$past(bus_req));

  // R7: an accepted access always passes through the wait window
  a_r7_window_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_nodev) |-> !$past(bus_req));

  // R7: the window counter stays in range
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/cfg_cycle_engine.sv
module cfg_cycle_engine
  import cfgx_pkg::*;
#(
  parameter int WAIT_CYC = 10000,
  parameter int MAX_DEV0 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_fn,
  input  logic [7:0]        req_off,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              abort_clr,
  output logic              busy,
  output logic              done,
  output logic              resp_nodev,
  output logic [31:0]       resp_rdata,
  output logic              abort_sticky,
  input  logic [31:0]       bext_q,
  output logic              bext_we,
  output logic [31:0]       bext_wd,
  output logic              bus_req,
  output logic              bus_write,
  output logic [36:0]       bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_err
);
  creq_t             req_q;
  creq_t             req_in;
  logic              accept;
  logic              is_type1, is_nodev;
  logic [DATA_W-1:0] raw_rdata;
  logic              err_seen;
  logic              sticky_q, sticky_d;

  assign accept = req_valid & ~busy;

  assign req_in = '{write: req_write, bus: req_bus, dev: req_dev,
                    fn: req_fn, off: req_off, size: req_size,
                    wdata: req_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else if (accept) req_q <= req_in;
  end

  cfgx_addr_gen #(.MAX_DEV0(MAX_DEV0)) u_addr (
    .bus         (req_q.bus),
    .dev         (req_q.dev),
    .fn          (req_q.fn),
    .dword       (req_q.off[7:2]),
    .size        (req_q.size),
    .is_type1    (is_type1),
    .is_nodev    (is_nodev),
    .sparse_addr (bus_addr)
  );

  cfgx_lane u_lane (
    .byte_sel   (req_q.off[1:0]),
    .host_wdata (req_q.wdata),
    .raw_rdata  (raw_rdata),
    .force_ones (err_seen | is_nodev),
    .bus_wdata  (bus_wdata),
    .host_rdata (resp_rdata)
  );

  cfgx_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .is_type1  (is_type1),
    .is_nodev  (is_nodev),
    .bext_q    (bext_q),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .bus_req   (bus_req),
    .bext_we   (bext_we),
    .bext_wd   (bext_wd),
    .raw_rdata (raw_rdata),
    .err_seen  (err_seen),
    .done      (done)
  );

  assign bus_write  = req_q.write;
  assign resp_nodev = done & is_nodev;

  always_comb begin
    sticky_d = sticky_q;
    if (done && err_seen && !is_nodev) sticky_d = 1'b1;
    else if (abort_clr)                sticky_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= sticky_d;
  end

  assign abort_sticky = sticky_q;

  // R1: bus-0 address selects exactly one device line
  a_r1_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !is_type1) |-> $onehot(bus_addr[36:16]));

  // R3: routed address keeps its upper byte clear
  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && is_type1) |-> (bus_addr[36:29] == 8'd0));

  // R10: busy only rises on a presented request
  a_r10_accept_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R11: sticky abort holds until cleared
  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_sticky && !abort_clr) |=> abort_sticky);
endmodule

// File: tb/cfg_cycle_engine_tb_top.sv
module cfg_cycle_engine_tb_top;
  localparam int W = 8;

  typedef struct {
    logic [36:0] addr;
    logic        wr;
    logic [31:0] wdata;
    logic        t1;
    logic [29:0] bext_low;
  } bus_exp_t;

  typedef struct {
    logic [31:0] rdata;
    logic        chk_rd;
    logic        nodev;
    int          lat;
    logic        from_ack;
    logic [31:0] bext_after;
  } rsp_exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_off = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0, req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        abort_clr = 1'b0;
  logic        busy, done, resp_nodev, abort_sticky;
  logic [31:0] resp_rdata;
  logic [31:0] bext_r;
  logic        bext_we;
  logic [31:0] bext_wd;
  logic        bext_load = 1'b1;
  logic [31:0] bext_preset = '0;
  logic        bus_req, bus_write;
  logic [36:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  cfg_cycle_engine #(.WAIT_CYC(W), .MAX_DEV0(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata), .abort_clr(abort_clr),
    .busy(busy), .done(done), .resp_nodev(resp_nodev), .resp_rdata(resp_rdata),
    .abort_sticky(abort_sticky), .bext_q(bext_r), .bext_we(bext_we),
    .bext_wd(bext_wd), .bus_req(bus_req), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int total = 0, bad = 0;
  int cyc = 0, ack_cyc = 0, req_cyc = 0, err_cyc = -100;
  int bus_cnt = 0, rsp_cnt = 0;
  int err_after = -1, wait_left = 0;
  bit acc_on = 1'b0, all_done = 1'b0;
  bus_exp_t bus_q[$];
  rsp_exp_t rsp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (bext_we)        bext_r <= bext_wd;
    else if (bext_load) bext_r <= bext_preset;
  end

  function automatic logic [31:0] model_rd(input logic [36:0] a);
    return a[36:5] ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // bus responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_ack) bus_ack = 1'b0;
      if (bus_req && !acc_on) begin
        acc_on    = 1'b1;
        wait_left = 1;
        if (bus_q.size() == 0) begin
          chk(1'b0, "R2/R10", "unexpected bus access", 64'(bus_addr), 0);
        end else begin
          bus_exp_t e;
          e = bus_q.pop_front();
          chk(bus_addr == e.addr, "R1/R3/R5", "bus address", 64'(bus_addr), 64'(e.addr));
          chk(bus_write == e.wr, "R6", "bus direction", 64'(bus_write), 64'(e.wr));
          if (e.wr)
            chk(bus_wdata == e.wdata, "R6", "write lanes", 64'(bus_wdata), 64'(e.wdata));
          if (e.t1)
            chk(bext_r == {2'b01, e.bext_low}, "R4", "mode field during access",
                64'(bext_r), 64'({2'b01, e.bext_low}));
        end
      end
      if (acc_on) begin
        if (wait_left == 0) begin
          bus_ack   = 1'b1;
          bus_rdata = model_rd(bus_addr);
          ack_cyc   = cyc;
          bus_cnt++;
          acc_on    = 1'b0;
          err_cyc   = (err_after >= 0) ? cyc + err_after : -100;
        end else begin
          wait_left--;
        end
      end
      bus_err = (cyc == err_cyc);
      if (done) begin
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          rsp_exp_t r;
          int lat;
          r = rsp_q.pop_front();
          lat = r.from_ack ? (cyc - ack_cyc) : (cyc - req_cyc);
          chk(lat == r.lat, "R7/R2", "done latency", 64'(lat), 64'(r.lat));
          chk(resp_nodev == r.nodev, "R2", "nodev flag", 64'(resp_nodev), 64'(r.nodev));
          if (r.chk_rd)
            chk(resp_rdata == r.rdata, "R6/R8", "read result", 64'(resp_rdata), 64'(r.rdata));
          chk(bext_r == r.bext_after, "R4", "bank-extension after access",
              64'(bext_r), 64'(r.bext_after));
          chk(busy == 1'b1, "R10", "busy with done", 64'(busy), 1);
        end
        rsp_cnt++;
      end
    end
  end

  task automatic access(input bit wr, input logic [7:0] b, input logic [4:0] d,
                        input logic [2:0] f, input logic [7:0] o, input logic [2:0] sz,
                        input logic [31:0] wd, input int err_k, input bit exp_err,
                        input int hold_extra);
    logic [31:0] cfg;
    logic [36:0] a;
    logic [4:0]  sh;
    bit nodev, t1, st0;
    int bc0, rc0;
    bus_exp_t be;
    rsp_exp_t re;
    t1    = (b != 0);
    nodev = !t1 && (d > 8);
    sh    = {o[1:0], 3'b000};
    if (!t1) cfg = (32'h800 << d) | (32'(f) << 8) | 32'(o & 8'hFC);
    else     cfg = (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | 32'(o & 8'hFC);
    a = {cfg, 5'b0} + 37'((sz - 1) * 8);
    if (!nodev) begin
      be.addr = a; be.wr = wr; be.wdata = wd << sh; be.t1 = t1;
      be.bext_low = bext_r[29:0];
      bus_q.push_back(be);
    end
    re.nodev    = nodev;
    re.chk_rd   = nodev || !wr;
    re.rdata    = (nodev || exp_err) ? 32'hFFFF_FFFF : (model_rd(a) >> sh);
    re.lat      = nodev ? 2 : (W + 1 + (t1 ? 1 : 0));
    re.from_ack = !nodev;
    re.bext_after = t1 ? {2'b00, bext_r[29:0]} : bext_r;
    rsp_q.push_back(re);
    err_after = err_k;
    bc0 = bus_cnt; rc0 = rsp_cnt; st0 = abort_sticky;
    req_write = wr; req_bus = b; req_dev = d; req_fn = f; req_off = o;
    req_size = sz; req_wdata = wd; req_valid = 1'b1;
    req_cyc = cyc;
    @(negedge clk);
    chk(busy == 1'b1, "R10", "busy after accept", 64'(busy), 1);
    if (hold_extra > 0) begin
      req_bus = b + 8'd3; req_dev = d ^ 5'd1; req_off = o ^ 8'h40; req_write = !wr;
      repeat (hold_extra) @(negedge clk);
    end
    req_valid = 1'b0;
    while (rsp_cnt == rc0) @(negedge clk);
    @(negedge clk);
    chk(bus_cnt - bc0 == (nodev ? 0 : 1), "R2/R10", "bus access count",
        64'(bus_cnt - bc0), 64'(nodev ? 0 : 1));
    chk(abort_sticky == (exp_err | st0), "R11", "sticky after done",
        64'(abort_sticky), 64'(exp_err | st0));
    chk(busy == 1'b0, "R10", "idle after done", 64'(busy), 0);
    err_after = -1;
  endtask

  task automatic clear_sticky();
    abort_clr = 1'b1;
    @(negedge clk);
    abort_clr = 1'b0;
    chk(abort_sticky == 1'b0, "R11", "sticky cleared", 64'(abort_sticky), 0);
  endtask

  task automatic preset_bext(input logic [31:0] v);
    bext_preset = v; bext_load = 1'b1;
    @(negedge clk);
    bext_load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bext_load = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10", "reset busy", 64'(busy), 0);
    chk(done == 1'b0, "R10", "reset done", 64'(done), 0);
    chk(bus_req == 1'b0, "R2", "reset bus_req", 64'(bus_req), 0);
    chk(abort_sticky == 1'b0, "R11", "reset sticky", 64'(abort_sticky), 0);
    chk(bext_we == 1'b0, "R4", "reset bext_we", 64'(bext_we), 0);
    // R1 R5 R6 plain bus-0 reads and a boundary device write
    access(1'b0, 8'd0, 5'd0, 3'd0, 8'h00, 3'd4, 32'h0, -1, 1'b0, 0);
    access(1'b0, 8'd0, 5'd3, 3'd5, 8'h3E, 3'd2, 32'h0, -1, 1'b0, 0);
    access(1'b1, 8'd0, 5'd8, 3'd7, 8'h11, 3'd1, 32'h0000_00AB, -1, 1'b0, 0);
    // R2 rejected device
    access(1'b0, 8'd0, 5'd9, 3'd1, 8'h04, 3'd4, 32'h0, -1, 1'b0, 0);
    // R3 R4 routed accesses
    preset_bext(32'hC000_1234);
    access(1'b0, 8'd5, 5'd17, 3'd2, 8'h87, 3'd1, 32'h0, -1, 1'b0, 0);
    preset_bext(32'h8765_4321);
    access(1'b1, 8'hFF, 5'd31, 3'd7, 8'hFE, 3'd2, 32'h0000_BEEF, -1, 1'b0, 0);
    // R8 R11 read error inside the window, then clear
    access(1'b0, 8'd0, 5'd2, 3'd0, 8'h08, 3'd4, 32'h0, 3, 1'b1, 0);
    clear_sticky();
    // R9 R7 write error on the acknowledge cycle
    access(1'b1, 8'd0, 5'd1, 3'd3, 8'h10, 3'd4, 32'h1234_5678, 0, 1'b1, 0);
    clear_sticky();
    // R7 R8 error in the last window cycle is counted
    access(1'b0, 8'd0, 5'd4, 3'd1, 8'h20, 3'd4, 32'h0, W, 1'b1, 0);
    clear_sticky();
    // R7 error one cycle past the window is ignored
    access(1'b0, 8'd0, 5'd4, 3'd1, 8'h24, 3'd4, 32'h0, W + 1, 1'b0, 0);
    // R8 routed read with error
    access(1'b0, 8'd1, 5'd0, 3'd0, 8'h00, 3'd4, 32'h0, 2, 1'b1, 0);
    clear_sticky();
    // R10 request held while busy is ignored
    access(1'b0, 8'd0, 5'd6, 3'd2, 8'h2D, 3'd1, 32'h0, -1, 1'b0, 3);
    repeat (3) @(negedge clk);
    chk(bus_q.size() == 0 && rsp_q.size() == 0, "R10", "scoreboard empty",
        64'(bus_q.size() + rsp_q.size()), 0);
    all_done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule